// File: doc/BRIEF.md
# Banked Control Register File

This block keeps the control state of a small 32-bit processor core: a status word made of a current byte and a saved byte, a second-level saved status byte, a condition flag, two banked stack pointers (one for interrupt/system mode, one for user mode), a saved program counter and its second-level copy, and two spare 32-bit slots. A combinational read port and a clocked write port are both addressed by a 4-bit control register number. Several reads return a masked or packed view instead of the raw stored bits.

The block also holds the live stack pointer that the core's general register file uses as its stack register. The live value is visible on `sp_q` and can be written through a dedicated port. Bit 7 of the current status byte selects the stack mode. A status write that flips this bit parks the live pointer in the bank of the mode being left and loads the live pointer from the bank of the mode being entered. The control register slot of the active mode maps onto the live pointer, and the slot of the inactive mode maps onto its banked copy.

Top module: `ctrl_reg_file`

## Requirements
- R1: After reset every control register number reads zero, `sp_q` is zero and user mode (status bit 7 = 0) is active.
- R2: Register 0 (status) reads as `((saved & 0xC1) << 8) | (current & 0xC0) | cond`, with bits 31:16 zero.
- R3: A write to register 0 loads data bits 15:8 into the saved status byte and bits 7:0 into the current byte, and data bit 0 becomes the condition flag.
- R4: Register 1 (condition) writes only the flag from data bit 0 and reads the flag in bit 0 with bits 31:1 zero.
- R5: A status write that sets bit 7 while it is clear stores the live pointer into the user bank and loads the live pointer from the interrupt bank.
- R6: A status write that clears bit 7 while it is set stores the live pointer into the interrupt bank and loads the live pointer from the user bank.
- R7: A status write that leaves bit 7 unchanged changes neither the live pointer nor either bank.
- R8: Register 2 (interrupt stack pointer) and register 3 (user stack pointer) read and write the live pointer when their mode is active and the banked copy otherwise.
- R9: Register 6 (saved PC) and register 8 (second-level saved PC) read with bit 0 forced to zero.
- R10: Register 7 (second-level saved status) holds data bits 7:0 and reads them masked with 0xC1.
- R11: Registers 4 and 5 are plain 32-bit storage that read back exactly what was written.
- R12: Register numbers 9 to 15 read zero, and writes to them change no register.
- R13: `sp_wr_en` loads `sp_wr_data` into the live pointer; a same-cycle control write to the active stack slot takes precedence, and a same-cycle mode-changing status write banks `sp_wr_data` as the value being parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 4 | Control register number to read |
| rd_data | output | 32 | Read view of the selected register (combinational) |
| wr_en | input | 1 | Control register write strobe |
| wr_idx | input | 4 | Control register number to write |
| wr_data | input | 32 | Write data |
| sp_wr_en | input | 1 | Write strobe for the live stack pointer from the register file |
| sp_wr_data | input | 32 | Live stack pointer write data |
| sp_q | output | 32 | Live stack pointer value |

## Verification
The hardest situation to reach from the ports is a mode-changing status write that lands in the same cycle as a register-file write of the live pointer. The parked value must then be the freshly written one, not the old register contents. The bench raises both strobes in one cycle and reads the parked value back through the now-inactive stack slot. It also overlaps an active-slot control write with a pointer-port write, so that the precedence rule shows up on `sp_q`.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int CR_IDX_W   = 4;
  localparam int SPARE_BASE = 4;

  typedef enum logic [CR_IDX_W-1:0] {
    CR_STATUS = 4'd0,
    CR_COND   = 4'd1,
    CR_ISP    = 4'd2,
    CR_USP    = 4'd3,
    CR_SAVPC  = 4'd6,
    CR_SAVST2 = 4'd7,
    CR_SAVPC2 = 4'd8
  } cr_idx_e;

  localparam logic [7:0] SAVED_KEEP = 8'hC1;
  localparam logic [7:0] CUR_KEEP   = 8'hC0;

  // Packed status view: saved byte high, current byte low, flag in bit 0.
  function automatic logic [15:0] status_view(input logic [7:0] saved,
                                              input logic [7:0] cur,
                                              input logic       flag);
    status_view = {saved & SAVED_KEEP, (cur & CUR_KEEP) | {7'd0, flag}};
  endfunction

  function automatic logic [7:0] saved2_view(input logic [7:0] raw);
    saved2_view = raw & SAVED_KEEP;
  endfunction

  function automatic logic [31:0] pc_view(input logic [31:0] raw);
    pc_view = {raw[31:1], 1'b0};
  endfunction
endpackage

// File: rtl/crf_status.sv
module crf_status
  import crf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_status,
  input  logic                wr_flag,
  input  logic [15:0]         wr_lo,
  output logic                stack_mode,
  output logic                mode_up,
  output logic                mode_down,
  output logic [XLEN-1:0]     status_rd,
  output logic [XLEN-1:0]     flag_rd
);
  logic [7:0] saved_q;
  logic [7:0] cur_q;
  logic       flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0;
      cur_q   <= '0;
      flag_q  <= 1'b0;
    end else if (wr_status) begin
      saved_q <= wr_lo[15:8];
      cur_q   <= wr_lo[7:0];
      flag_q  <= wr_lo[0];
    end else if (wr_flag) begin
      flag_q  <= wr_lo[0];
    end
  end

  assign stack_mode = cur_q[7];
  assign mode_up    = wr_status &  wr_lo[7] & ~cur_q[7];
  assign mode_down  = wr_status & ~wr_lo[7] &  cur_q[7];
  assign status_rd  = XLEN'(status_view(saved_q, cur_q, flag_q));
  assign flag_rd    = XLEN'(flag_q);

  assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> (status_rd[15:8] == ($past(wr_lo[15:8]) & 8'hC1)) &&
                  (status_rd[0] == $past(wr_lo[0])) &&
                  (stack_mode == $past(wr_lo[7])));

  assert_flag_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !wr_status) |=> (flag_rd == XLEN'($past(wr_lo[0]))) &&
                                $stable(stack_mode));

  assert_status_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_rd & ~XLEN'(16'hC1C1)) == '0) && (status_rd[0] == flag_rd[0]));
endmodule

// File: rtl/crf_stack_bank.sv
module crf_stack_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stack_mode,
  input  logic            mode_up,
  input  logic            mode_down,
  input  logic            wr_isp,
  input  logic            wr_usp,
  input  logic [XLEN-1:0] wr_data,
  input  logic            sp_wr_en,
  input  logic [XLEN-1:0] sp_wr_data,
  output logic [XLEN-1:0] sp_q,
  output logic [XLEN-1:0] isp_view,
  output logic [XLEN-1:0] usp_view
);
  logic [XLEN-1:0] live_q;
  logic [XLEN-1:0] isp_bank_q;
  logic [XLEN-1:0] usp_bank_q;
  logic [XLEN-1:0] live_eff;
  logic            live_hit;

  // Value the live pointer would carry after a register-file write alone.
  assign live_eff = sp_wr_en ? sp_wr_data : live_q;
  // A control write addressed at the active mode's slot.
  assign live_hit = (wr_isp & stack_mode) | (wr_usp & ~stack_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= '0;
      isp_bank_q <= '0;
      usp_bank_q <= '0;
    end else if (mode_up) begin
      usp_bank_q <= live_eff;
      live_q     <= isp_bank_q;
    end else if (mode_down) begin
      isp_bank_q <= live_eff;
      live_q     <= usp_bank_q;
    end else begin
      if (live_hit)      live_q <= wr_data;
      else if (sp_wr_en) live_q <= sp_wr_data;
      if (wr_isp && !stack_mode) isp_bank_q <= wr_data;
      if (wr_usp &&  stack_mode) usp_bank_q <= wr_data;
    end
  end

  assign sp_q     = live_q;
  assign isp_view = stack_mode ? live_q : isp_bank_q;
  assign usp_view = stack_mode ? usp_bank_q : live_q;

  assert_swap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_up |=> (usp_bank_q == $past(live_eff)) && (live_q == $past(isp_bank_q)));

  assert_swap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_down |=> (isp_bank_q == $past(live_eff)) && (live_q == $past(usp_bank_q)));

  assert_banks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_up && !mode_down && !wr_isp && !wr_usp) |=>
      $stable(isp_bank_q) && $stable(usp_bank_q));

  assert_live_prio_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hit && !mode_up && !mode_down) |=> (sp_q == $past(wr_data)));
endmodule

// File: rtl/crf_plain.sv
module crf_plain
  import crf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NSPARE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CR_IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]     wr_data,
  output logic [XLEN-1:0]     savpc_view,
  output logic [XLEN-1:0]     savpc2_view,
  output logic [XLEN-1:0]     savst2_view,
  output logic [XLEN-1:0]     spare_view [NSPARE]
);
  logic [XLEN-1:0] savpc_q;
  logic [XLEN-1:0] savpc2_q;
  logic [7:0]      savst2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      savpc_q  <= '0;
      savpc2_q <= '0;
      savst2_q <= '0;
    end else if (wr_en) begin
      if (wr_idx == CR_SAVPC)  savpc_q  <= wr_data;
      if (wr_idx == CR_SAVPC2) savpc2_q <= wr_data;
      if (wr_idx == CR_SAVST2) savst2_q <= wr_data[7:0];
    end
  end

  for (genvar i = 0; i < NSPARE; i++) begin : g_spare
    logic [XLEN-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (wr_en && wr_idx == CR_IDX_W'(SPARE_BASE + i))
        slot_q <= wr_data;
    end
    assign spare_view[i] = slot_q;

    assert_spare_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == CR_IDX_W'(SPARE_BASE + i)) |=> (spare_view[i] == $past(wr_data)));
  end

  assign savpc_view  = XLEN'(pc_view(32'(savpc_q)));
  assign savpc2_view = XLEN'(pc_view(32'(savpc2_q)));
  assign savst2_view = XLEN'(saved2_view(savst2_q));

  assert_pc_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (savpc_view[0] == 1'b0) && (savpc2_view[0] == 1'b0));

  assert_savst2_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_SAVST2) |=> (savst2_view == XLEN'($past(wr_data[7:0]) & 8'hC1)));
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import crf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NSPARE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CR_IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]     rd_data,
  input  logic                wr_en,
  input  logic [CR_IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]     wr_data,
  input  logic                sp_wr_en,
  input  logic [XLEN-1:0]     sp_wr_data,
  output logic [XLEN-1:0]     sp_q
);
  localparam int LAST_IMPL = 8;

  logic            wr_status, wr_flag, wr_isp, wr_usp;
  logic            stack_mode, mode_up, mode_down;
  logic [XLEN-1:0] status_rd, flag_rd, isp_view, usp_view;
  logic [XLEN-1:0] savpc_view, savpc2_view, savst2_view;
  logic [XLEN-1:0] spare_view [NSPARE];

  assign wr_status = wr_en && (wr_idx == CR_STATUS);
  assign wr_flag   = wr_en && (wr_idx == CR_COND);
  assign wr_isp    = wr_en && (wr_idx == CR_ISP);
  assign wr_usp    = wr_en && (wr_idx == CR_USP);

  crf_status #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_status(wr_status), .wr_flag(wr_flag), .wr_lo(wr_data[15:0]),
    .stack_mode(stack_mode), .mode_up(mode_up), .mode_down(mode_down),
    .status_rd(status_rd), .flag_rd(flag_rd)
  );

  crf_stack_bank #(.XLEN(XLEN)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .stack_mode(stack_mode), .mode_up(mode_up), .mode_down(mode_down),
    .wr_isp(wr_isp), .wr_usp(wr_usp), .wr_data(wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .sp_q(sp_q), .isp_view(isp_view), .usp_view(usp_view)
  );

  crf_plain #(.XLEN(XLEN), .NSPARE(NSPARE)) u_plain (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .savpc_view(savpc_view), .savpc2_view(savpc2_view),
    .savst2_view(savst2_view), .spare_view(spare_view)
  );

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      CR_STATUS: rd_data = status_rd;
      CR_COND:   rd_data = flag_rd;
      CR_ISP:    rd_data = isp_view;
      CR_USP:    rd_data = usp_view;
      CR_SAVPC:  rd_data = savpc_view;
      CR_SAVST2: rd_data = savst2_view;
      CR_SAVPC2: rd_data = savpc2_view;
      default: begin
        for (int i = 0; i < NSPARE; i++)
          if (rd_idx == CR_IDX_W'(SPARE_BASE + i)) rd_data = spare_view[i];
      end
    endcase
  end

  assert_unimpl_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) > LAST_IMPL) |-> (rd_data == '0));

  assert_active_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_idx == CR_ISP && stack_mode) || (rd_idx == CR_USP && !stack_mode)) |->
      (rd_data == sp_q));
endmodule

// File: tb/ctrl_reg_file_tb.sv
module ctrl_reg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = '0;
  logic [31:0] sp_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctrl_reg_file u_dut (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_q(sp_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic crw(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic spw(input logic [31:0] d);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = d;
    @(negedge clk);
    sp_wr_en = 1'b0;
  endtask

  task automatic crr(input logic [3:0] idx, output logic [31:0] v);
    rd_idx = idx;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      crr(4'(i), v);
      chk($sformatf("R1 reg%0d", i), v, 32'h0);
    end
    chk("R1 sp_q", sp_q, 32'h0);
    spw(32'h0000_0055);
    crr(4'd3, v);
    chk("R1 user mode active", v, 32'h0000_0055);
    crr(4'd2, v);
    chk("R1 interrupt bank untouched", v, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    crw(4'd0, 32'hFFFF_A543);
    crr(4'd0, v);
    chk("R2 R3 status view A543", v, 32'h0000_8141);
    crw(4'd0, 32'h0000_3E3E);
    crr(4'd0, v);
    chk("R2 R3 status view 3E3E", v, 32'h0000_0000);
    crr(4'd1, v);
    chk("R3 flag from status bit0", v, 32'h0);
  endtask

  task automatic t_flag();
    logic [31:0] v;
    crw(4'd1, 32'hFFFF_FFFF);
    crr(4'd1, v);
    chk("R4 flag reads bit0 only", v, 32'h1);
    crr(4'd0, v);
    chk("R4 flag in status bit0", v, 32'h1);
    crw(4'd1, 32'hFFFF_FFFE);
    crr(4'd1, v);
    chk("R4 flag cleared", v, 32'h0);
  endtask

  task automatic t_swap();
    logic [31:0] v;
    spw(32'h0000_1000);
    crw(4'd2, 32'h0000_2000);
    chk("R8 inactive write leaves live", sp_q, 32'h0000_1000);
    crw(4'd0, 32'h0000_0080);
    chk("R5 live loaded from interrupt bank", sp_q, 32'h0000_2000);
    crr(4'd3, v);
    chk("R5 user bank holds old live", v, 32'h0000_1000);
    crr(4'd2, v);
    chk("R8 active interrupt slot is live", v, 32'h0000_2000);
    spw(32'h0000_2222);
    crw(4'd0, 32'h0000_0000);
    chk("R6 live loaded from user bank", sp_q, 32'h0000_1000);
    crr(4'd2, v);
    chk("R6 interrupt bank holds old live", v, 32'h0000_2222);
  endtask

  task automatic t_noswap();
    logic [31:0] v;
    crw(4'd0, 32'h0000_FF41);
    chk("R7 user mode hold live", sp_q, 32'h0000_1000);
    crr(4'd2, v);
    chk("R7 user mode hold isp", v, 32'h0000_2222);
    crw(4'd0, 32'h0000_0080);
    chk("R5 second entry", sp_q, 32'h0000_2222);
    crw(4'd0, 32'h0000_00C1);
    chk("R7 system mode hold live", sp_q, 32'h0000_2222);
    crr(4'd3, v);
    chk("R7 system mode hold usp", v, 32'h0000_1000);
  endtask

  task automatic t_slots();
    logic [31:0] v;
    crw(4'd2, 32'h0000_3330);
    chk("R8 active isp write to live", sp_q, 32'h0000_3330);
    crw(4'd3, 32'h0000_4440);
    chk("R8 inactive usp write keeps live", sp_q, 32'h0000_3330);
    crr(4'd3, v);
    chk("R8 usp bank readback", v, 32'h0000_4440);
  endtask

  task automatic t_sp_port();
    logic [31:0] v;
    // system mode active: slot 2 is live
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h0000_5550;
    sp_wr_en = 1'b1; sp_wr_data = 32'h0000_6660;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    chk("R13 control write wins", sp_q, 32'h0000_5550);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0000;
    sp_wr_en = 1'b1; sp_wr_data = 32'h0000_7770;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    chk("R13 R6 live from user bank", sp_q, 32'h0000_4440);
    crr(4'd2, v);
    chk("R13 parked value is port data", v, 32'h0000_7770);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    crw(4'd6, 32'hDEAD_BEEF);
    crr(4'd6, v);
    chk("R9 saved pc bit0 clear", v, 32'hDEAD_BEEE);
    crw(4'd8, 32'h1234_5679);
    crr(4'd8, v);
    chk("R9 second saved pc bit0 clear", v, 32'h1234_5678);
    crw(4'd7, 32'hFFFF_FFFF);
    crr(4'd7, v);
    chk("R10 second saved status mask", v, 32'h0000_00C1);
    crw(4'd7, 32'h0000_0180);
    crr(4'd7, v);
    chk("R10 8-bit storage", v, 32'h0000_0080);
    crw(4'd4, 32'hA5A5_0F0F);
    crw(4'd5, 32'h0123_4567);
    crr(4'd4, v);
    chk("R11 spare 4", v, 32'hA5A5_0F0F);
    crr(4'd5, v);
    chk("R11 spare 5", v, 32'h0123_4567);
  endtask

  task automatic t_unimpl();
    logic [31:0] snap [9];
    logic [31:0] spsnap;
    logic [31:0] v;
    for (int i = 0; i < 9; i++) crr(4'(i), snap[i]);
    spsnap = sp_q;
    for (int i = 9; i < 16; i++) crw(4'(i), 32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) begin
      crr(4'(i), v);
      chk($sformatf("R12 reg%0d unchanged", i), v, snap[i]);
    end
    chk("R12 sp unchanged", sp_q, spsnap);
    for (int i = 9; i < 16; i++) begin
      crr(4'(i), v);
      chk($sformatf("R12 reg%0d reads zero", i), v, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_flag();
    t_swap();
    t_noswap();
    t_slots();
    t_sp_port();
    t_plain();
    t_unimpl();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule